// File: doc/BRIEF.md
# Synchronized Strobe Address Capture

This block latches an external bus address when an address strobe from outside the chip rises. The strobe is never used as a clock. It passes through a chain of flip-flops clocked by the system clock, so that any metastable settling stays inside the first stage. A rising edge of the resolved strobe level then produces a pulse that lasts one clock cycle. That pulse is the load enable of an ordinary system-clocked register that holds address bits 23 down to 1.

Downstream logic, typically a bus sequencing state machine, receives three signals. It gets the resolved strobe level, the one-cycle edge pulse and the captured address. It never sees the raw strobe input. Compared with a register clocked by the strobe, the level and the pulse arrive one clock later. The address source must therefore hold the address for three clock cycles after the strobe rises.

Top module: `sac_strobe_capture`

## Requirements
- R1: While `rst_n` is low, `addr_q`, `edge_pulse` and `strobe_sync` are 0, whatever `strobe_in` does. Asserting `rst_n` clears them at once, without waiting for a clock edge.
- R2: `strobe_sync` is the value of `strobe_in` that was sampled two rising clock edges earlier. A level sampled at edge k appears just after edge k+1.
- R3: `edge_pulse` is 1 for exactly the one cycle in which `strobe_sync` is 1 and was 0 in the cycle before. In every other cycle it is 0.
- R4: At the clock edge that ends a cycle with `edge_pulse` high, `addr_q` loads the value present on `addr_in` at that edge. That is the third rising edge after the strobe is first sampled high.
- R5: On any edge that does not follow an `edge_pulse` cycle, `addr_q` keeps its value, whatever `addr_in` does.
- R6: A falling strobe produces no pulse and no capture.
- R7: A strobe held high for any number of cycles produces one pulse and one capture.
- R8: A strobe that is high for one sample, low for one sample and then high again produces two separate pulses and two captures.
- R9: All 23 bits, `addr_in[23:1]`, are captured independently. Bit i of the input lands in bit i of `addr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_in | input | 1 | Address strobe, asynchronous to `clk` |
| addr_in | input | 23 | Bus address bits 23:1 |
| addr_q | output | 23 | Captured address bits 23:1 |
| edge_pulse | output | 1 | One-cycle pulse on a rising edge of the resolved strobe |
| strobe_sync | output | 1 | Strobe level after synchronization |

## Verification
The bench builds the block with its defaults: a field of bits 23:1 and two synchronizer stages. With these values, a walking one across the full 23-bit field is within reach. So is the exact two-edge latency of the level and the three-edge capture latency. Strobe patterns cover one-sample highs, long holds, falls, and address changes while the enable is idle. A reset is also applied in the middle of a run.

// File: rtl/sac_pkg.sv
package sac_pkg;

    // History kept by the edge detector: last resolved strobe level
    typedef struct packed {
        logic last_lvl;
    } edge_hist_t;

    function automatic logic rising(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [N-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[N-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[N-1];

    AST_SYNC_RESET_LOW: assert property (@(posedge clk) !rst_n |-> !sync_out); // R1
endmodule

// File: rtl/sac_edge.sv
module sac_edge
    import sac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic rise_pulse
);
    edge_hist_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.last_lvl = lvl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_pulse = rising(lvl_in, st_q.last_lvl);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise_pulse |=> !rise_pulse); // R3
    AST_PULSE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n) rise_pulse |-> (lvl_in && !$past(lvl_in))); // R3
    AST_NO_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(lvl_in) |-> !rise_pulse); // R6
endmodule

// File: rtl/sac_capture.sv
module sac_capture #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] addr;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.addr = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.addr;

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) $past(load) |-> (q == $past(d))); // R4
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(load) |-> $stable(q)); // R5
endmodule

// File: rtl/sac_strobe_capture.sv
module sac_strobe_capture #(
    parameter int ADDR_MSB    = 23,
    parameter int ADDR_LSB    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe_in,
    input  logic [ADDR_MSB:ADDR_LSB] addr_in,
    output logic [ADDR_MSB:ADDR_LSB] addr_q,
    output logic                   edge_pulse,
    output logic                   strobe_sync
);
    localparam int ADDR_W = ADDR_MSB - ADDR_LSB + 1;

    logic              lvl_s;
    logic              pulse_s;
    logic [ADDR_W-1:0] cap_s;

    sac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (strobe_in),
        .sync_out (lvl_s)
    );

    sac_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_in     (lvl_s),
        .rise_pulse (pulse_s)
    );

    sac_capture #(.W(ADDR_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pulse_s),
        .d     (addr_in),
        .q     (cap_s)
    );

    assign addr_q      = cap_s;
    assign edge_pulse  = pulse_s;
    assign strobe_sync = lvl_s;

    // Edges seen since reset, saturating; lets the latency check look back safely
    logic [1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (age_q != 2'd3) age_d = age_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (addr_q == '0 && !edge_pulse && !strobe_sync)); // R1

    generate
        if (SYNC_STAGES == 2) begin : g_lat2
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (age_q >= 2'd2) |-> (strobe_sync == $past(strobe_in, 2))); // R2
        end
    endgenerate
endmodule

// File: tb/sac_strobe_capture_test.sv
module sac_strobe_capture_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe_in;
    logic [23:1] addr_in;
    logic [23:1] addr_q;
    logic        edge_pulse;
    logic        strobe_sync;

    always #2 clk = ~clk;   // 250 MHz

    sac_strobe_capture uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_in   (strobe_in),
        .addr_in     (addr_in),
        .addr_q      (addr_q),
        .edge_pulse  (edge_pulse),
        .strobe_sync (strobe_sync)
    );

    int    checks = 0;
    int    fails  = 0;
    int    pulse_cnt = 0;
    string tag = "R4";

    // Behavioural reference: queue of strobe samples, newest first
    bit          hist[$];
    logic [22:0] exp_addr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist     = '{1'b0, 1'b0, 1'b0};
            exp_addr = '0;
        end else begin
            if (hist[1] && !hist[2]) exp_addr = addr_in;
            hist.push_front(strobe_in);
            hist.pop_back();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_now();
        chk(strobe_sync === hist[1], "R2 strobe_sync", {31'd0, strobe_sync}, {31'd0, hist[1]});
        chk(edge_pulse === (hist[1] && !hist[2]), "R3 edge_pulse",
            {31'd0, edge_pulse}, {31'd0, (hist[1] && !hist[2])});
        chk(addr_q === exp_addr, {tag, " addr_q"}, {9'd0, addr_q}, {9'd0, exp_addr});
        if (edge_pulse) pulse_cnt++;
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic cyc(input logic s, input logic [22:0] a);
        strobe_in = s;
        addr_in   = a;
        @(posedge clk);
        @(negedge clk);
        compare_now();
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        strobe_in = 1'b1;
        addr_in   = 23'h5A5A5A;
        repeat (4) @(negedge clk);
        tag = "R1";
        chk(addr_q == '0 && !edge_pulse && !strobe_sync, "R1 reset state",
            {8'd0, addr_q, edge_pulse, strobe_sync}, 32'd0);
        strobe_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 23'h0);
        cyc(1'b0, 23'h0);

        // R4: basic capture, address held three cycles after the rise
        tag = "R4";
        cyc(1'b0, 23'h123456);
        repeat (4) cyc(1'b1, 23'h123456);
        chk(addr_q == 23'h123456, "R4 captured value", {9'd0, addr_q}, 32'h123456);
        repeat (3) cyc(1'b0, 23'h123456);

        // R9: walking one across the whole field
        tag = "R9";
        for (int i = 0; i < 23; i++) begin
            repeat (3) cyc(1'b1, 23'(1) << i);
            cyc(1'b1, 23'h7FFFFF);
            chk(addr_q == (23'(1) << i), "R9 walking bit", {9'd0, addr_q}, {9'd0, 23'(1) << i});
            repeat (3) cyc(1'b0, 23'h0);
        end

        // R5: address churn while no capture is enabled
        tag = "R5";
        begin
            logic [22:0] held;
            held = addr_q;
            for (int i = 0; i < 8; i++) cyc(1'b0, 23'h3C0F00 ^ 23'(i * 97));
            chk(addr_q == held, "R5 hold while idle", {9'd0, addr_q}, {9'd0, held});
        end

        // R7: long hold gives one pulse; later address changes are ignored
        tag = "R7";
        pulse_cnt = 0;
        repeat (3) cyc(1'b1, 23'h0ABCDE);
        for (int i = 0; i < 20; i++) cyc(1'b1, 23'h600000 + 23'(i));
        chk(pulse_cnt == 1, "R7 pulse count", pulse_cnt, 1);
        chk(addr_q == 23'h0ABCDE, "R7 value kept", {9'd0, addr_q}, 32'h0ABCDE);

        // R6: the fall produces no pulse and no capture
        tag = "R6";
        pulse_cnt = 0;
        for (int i = 0; i < 6; i++) cyc(1'b0, 23'h111111 * 23'(i + 1));
        chk(pulse_cnt == 0, "R6 pulses on fall", pulse_cnt, 0);
        chk(addr_q == 23'h0ABCDE, "R6 no capture on fall", {9'd0, addr_q}, 32'h0ABCDE);

        // R8: high one sample, low one sample, high again
        tag = "R8";
        pulse_cnt = 0;
        cyc(1'b1, 23'h000AAA);
        cyc(1'b0, 23'h000AAA);
        cyc(1'b1, 23'h000AAA);
        cyc(1'b0, 23'h000BBB);
        cyc(1'b0, 23'h000BBB);
        repeat (4) cyc(1'b0, 23'h000CCC);
        chk(pulse_cnt == 2, "R8 pulse count", pulse_cnt, 2);
        chk(addr_q == 23'h000BBB, "R8 second capture", {9'd0, addr_q}, 32'h000BBB);

        // R1: reset in mid-run clears at once
        tag = "R1";
        repeat (3) cyc(1'b1, 23'h7FFFFF);
        #1;
        rst_n = 1'b0;
        #1;
        chk(addr_q == '0 && !edge_pulse && !strobe_sync, "R1 async clear",
            {8'd0, addr_q, edge_pulse, strobe_sync}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) cyc(1'b0, 23'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule